// File: doc/BRIEF.md
# Single-Cycle Load/Store Integer Core

This block is a small integer processor that finishes every instruction in one clock. It fetches a 32-bit word from a read-only instruction store and decodes it. It then reads two operands from a 32-entry register file and computes through one ALU. In the same cycle it either writes the register file or writes a word to a separate data store. At the end of the cycle it picks the next program counter from three candidates: the next word, a PC-relative branch target or a region-absolute jump target.

The core supports nine operations. The register-to-register group is add, subtract, bitwise and, bitwise or and signed set-on-less-than. The other four are word load, word store, branch-if-equal and unconditional jump. Both stores are small internal word arrays that are filled in before reset is released. The register-write and store-write ports of the datapath are brought out as observation outputs, next to the current PC and the fetched word. An environment can follow every architectural change as it happens.

Top module: `onecyc_core`

## Requirements
- R1: `rst` is active high and sampled on the rising clock edge. While it is high, the PC becomes 0 and all 32 registers become 0.
- R2: Any instruction that is neither a branch nor a jump sets the next PC to PC+4.
- R3: Opcode 4 is branch-if-equal. It subtracts rt from rs. If the result is zero, the next PC is PC+4 plus the sign-extended 16-bit immediate shifted left by two. Otherwise the next PC is PC+4.
- R4: Opcode 2 is jump. The next PC is bits 31:28 of the current PC, then instruction bits 25:0, then two zero bits.
- R5: Opcode 43 is store word. It writes the value of register rt (bits 20:16) to the data word selected by rs (bits 25:21) plus the sign-extended immediate (bits 15:0). The word index is taken from the address bits above bit 1. A store never writes the register file.
- R6: Opcode 35 is load word. It forms its address as in R5 and writes the selected data word into register rt.
- R7: Opcode 0 with funct (bits 5:0) 0x20, 0x22, 0x24, 0x25 or 0x2A writes rs+rt, rs-rt, rs AND rt, rs OR rt, or the signed rs<rt flag, to register rd (bits 15:11).
- R8: Register 0 always reads as zero. A write aimed at it has no effect.
- R9: Any other opcode, and any other funct under opcode 0, writes neither the registers nor the data store, and advances the PC by 4.
- R10: Register and data-store writes take effect at the rising edge that ends the instruction. Reads are combinational, so the next instruction sees the new value.
- R11: The instruction store is never modified by execution. The fetched word always equals the word preloaded at that PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| pc_o | output | 32 | Address of the instruction being executed |
| instr_o | output | 32 | Instruction word fetched at `pc_o` |
| rf_we_o | output | 1 | Register write requested by this instruction |
| rf_waddr_o | output | 5 | Destination register number |
| rf_wdata_o | output | 32 | Value to be written to the destination |
| dm_we_o | output | 1 | Data-store write for this instruction |
| dm_addr_o | output | 32 | Byte address computed by the ALU |
| dm_wdata_o | output | 32 | Word to be stored |

## Verification
The assertions assume that every fetched word was preloaded, so the opcode field is never unknown. They also assume that `rst` is held high through at least one rising edge before execution starts. The bench fills both stores by hierarchical assignment before releasing reset, and it writes only word-aligned data addresses. The program places its data addresses, including one reached through a negative offset, inside the data store so that index wrap-around does not occur. Control flow is kept inside the preloaded region, so the PC-region bits in the jump rule are always zero.

// File: rtl/core_pkg.sv
package core_pkg;

  localparam int XLEN = 32;

  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_JUMP  = 6'd2;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_LOAD  = 6'd35;
  localparam logic [5:0] OP_STORE = 6'd43;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_sel_e;

  typedef struct packed {
    logic     dst_is_rd;
    logic     b_is_imm;
    logic     wb_from_mem;
    logic     reg_write;
    logic     mem_write;
    logic     is_branch;
    logic     is_jump;
    alu_sel_e alu_sel;
  } ctrl_t;

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] branch_target(input logic [XLEN-1:0] pc_next,
                                                    input logic [15:0] off);
    return pc_next + (sext16(off) << 2);
  endfunction

  function automatic logic [XLEN-1:0] jump_target(input logic [XLEN-1:0] pc_cur,
                                                  input logic [25:0] word_idx);
    return {pc_cur[XLEN-1:28], word_idx, 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] alu_calc(input alu_sel_e sel,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    logic [XLEN-1:0] r;
    unique case (sel)
      ALU_AND: r = a & b;
      ALU_OR:  r = a | b;
      ALU_ADD: r = a + b;
      ALU_SUB: r = a - b;
      ALU_SLT: r = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/core_ctrl.sv
module core_ctrl
  import core_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctl
);

  logic [1:0] alu_class;
  logic       funct_known;

  always_comb begin
    ctl       = '0;
    ctl.alu_sel = ALU_ADD;
    alu_class = 2'b00;
    unique case (opcode)
      OP_LOAD: begin
        ctl.b_is_imm    = 1'b1;
        ctl.wb_from_mem = 1'b1;
        ctl.reg_write   = 1'b1;
      end
      OP_STORE: begin
        ctl.b_is_imm  = 1'b1;
        ctl.mem_write = 1'b1;
      end
      OP_BEQ: begin
        ctl.is_branch = 1'b1;
        alu_class     = 2'b01;
      end
      OP_JUMP: begin
        ctl.is_jump = 1'b1;
        alu_class   = 2'b11;
      end
      OP_RTYPE: begin
        ctl.dst_is_rd = 1'b1;
        ctl.reg_write = funct_known;
        alu_class     = 2'b10;
      end
      default: ;
    endcase

    unique case (alu_class)
      2'b01: ctl.alu_sel = ALU_SUB;
      2'b10: begin
        unique case (funct)
          FN_SUB:  ctl.alu_sel = ALU_SUB;
          FN_AND:  ctl.alu_sel = ALU_AND;
          FN_OR:   ctl.alu_sel = ALU_OR;
          FN_SLT:  ctl.alu_sel = ALU_SLT;
          default: ctl.alu_sel = ALU_ADD;
        endcase
      end
      default: ctl.alu_sel = ALU_ADD;
    endcase
  end

  always_comb begin
    unique case (funct)
      FN_ADD, FN_SUB, FN_AND, FN_OR, FN_SLT: funct_known = 1'b1;
      default:                               funct_known = 1'b0;
    endcase
  end

endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int NREG  = 32,
  parameter int WIDTH = 32,
  parameter int AW    = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    ra1,
  input  logic [AW-1:0]    ra2,
  output logic [WIDTH-1:0] rd1,
  output logic [WIDTH-1:0] rd2,
  input  logic             we,
  input  logic [AW-1:0]    wa,
  input  logic [WIDTH-1:0] wd
);

  logic [WIDTH-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && (wa != '0)) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

endmodule

// File: rtl/core_mem.sv
module core_mem #(
  parameter int WORDS = 64,
  parameter int WIDTH = 32,
  parameter int AW    = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    idx,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] cells [WORDS];

  always_ff @(posedge clk) begin
    if (we) cells[idx] <= wdata;
  end

  assign rdata = cells[idx];

endmodule

// File: rtl/core_alu.sv
module core_alu
  import core_pkg::*;
(
  input  alu_sel_e         sel,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  output logic [XLEN-1:0]  y,
  output logic             is_zero
);

  assign y       = alu_calc(sel, a, b);
  assign is_zero = (y == '0);

endmodule

// File: rtl/onecyc_core.sv
module onecyc_core
  import core_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter int NREG       = 32
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] pc_o,
  output logic [31:0] instr_o,
  output logic        rf_we_o,
  output logic [4:0]  rf_waddr_o,
  output logic [31:0] rf_wdata_o,
  output logic        dm_we_o,
  output logic [31:0] dm_addr_o,
  output logic [31:0] dm_wdata_o
);

  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);
  localparam int RAW = $clog2(NREG);

  logic [XLEN-1:0] pc_q, pc_d, pc_plus4, br_tgt, jmp_tgt;
  logic [XLEN-1:0] instr, rs_val, rt_val, imm_ext, alu_b, alu_y, ld_word, wb_val;
  logic [RAW-1:0]  dst_reg;
  logic            alu_zero, br_taken;
  ctrl_t           ctl;

  // fetch: word-wide store, write path held off
  core_mem #(.WORDS(IMEM_WORDS), .WIDTH(XLEN)) u_imem (
    .clk   (clk),
    .we    (1'b0),
    .idx   (pc_q[IAW+1:2]),
    .wdata ('0),
    .rdata (instr)
  );

  core_ctrl u_ctrl (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctl    (ctl)
  );

  assign dst_reg = ctl.dst_is_rd ? instr[15:11] : instr[20:16];

  core_regfile #(.NREG(NREG), .WIDTH(XLEN)) u_rf (
    .clk (clk),
    .rst (rst),
    .ra1 (instr[25:21]),
    .ra2 (instr[20:16]),
    .rd1 (rs_val),
    .rd2 (rt_val),
    .we  (ctl.reg_write),
    .wa  (dst_reg),
    .wd  (wb_val)
  );

  assign imm_ext = sext16(instr[15:0]);
  assign alu_b   = ctl.b_is_imm ? imm_ext : rt_val;

  core_alu u_alu (
    .sel     (ctl.alu_sel),
    .a       (rs_val),
    .b       (alu_b),
    .y       (alu_y),
    .is_zero (alu_zero)
  );

  core_mem #(.WORDS(DMEM_WORDS), .WIDTH(XLEN)) u_dmem (
    .clk   (clk),
    .we    (ctl.mem_write),
    .idx   (alu_y[DAW+1:2]),
    .wdata (rt_val),
    .rdata (ld_word)
  );

  assign wb_val = ctl.wb_from_mem ? ld_word : alu_y;

  // next-PC selection
  assign pc_plus4 = pc_q + 32'd4;
  assign br_tgt   = branch_target(pc_plus4, instr[15:0]);
  assign jmp_tgt  = jump_target(pc_q, instr[25:0]);
  assign br_taken = ctl.is_branch & alu_zero;

  always_comb begin
    if (ctl.is_jump)  pc_d = jmp_tgt;
    else if (br_taken) pc_d = br_tgt;
    else              pc_d = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_d;
  end

  assign pc_o       = pc_q;
  assign instr_o    = instr;
  assign rf_we_o    = ctl.reg_write;
  assign rf_waddr_o = dst_reg;
  assign rf_wdata_o = wb_val;
  assign dm_we_o    = ctl.mem_write;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = rt_val;

endmodule

// File: rtl/core_chk.sv
module core_chk
  import core_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc_o,
  input logic [31:0] instr_o,
  input logic        rf_we_o,
  input logic [4:0]  rf_waddr_o,
  input logic [31:0] rf_wdata_o,
  input logic        dm_we_o,
  input logic [31:0] dm_addr_o,
  input logic [31:0] dm_wdata_o
);

  logic [5:0] op;
  logic [5:0] fn;
  logic       known_op;
  assign op = instr_o[31:26];
  assign fn = instr_o[5:0];
  assign known_op = (op == OP_RTYPE) || (op == OP_JUMP) || (op == OP_BEQ) ||
                    (op == OP_LOAD) || (op == OP_STORE);

  // R1: reset drives the PC to zero
  a_r1_reset_pc: assert property (@(posedge clk) rst |=> pc_o == 32'd0);

  a_r2_sequential: assert property (@(posedge clk) disable iff (rst)
    (op != OP_BEQ && op != OP_JUMP) |=> pc_o == $past(pc_o) + 32'd4);

  a_r3_branch_dest: assert property (@(posedge clk) disable iff (rst)
    (op == OP_BEQ) |=> (pc_o == $past(pc_o) + 32'd4) ||
      (pc_o == $past(pc_o) + 32'd4 + {{14{$past(instr_o[15])}}, $past(instr_o[15:0]), 2'b00}));

  a_r4_jump_dest: assert property (@(posedge clk) disable iff (rst)
    (op == OP_JUMP) |=> pc_o == {$past(pc_o[31:28]), $past(instr_o[25:0]), 2'b00});

  a_r5_store_only: assert property (@(posedge clk) disable iff (rst)
    dm_we_o |-> (op == OP_STORE) && !rf_we_o);

  a_r6_load_dest: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LOAD) |-> rf_we_o && (rf_waddr_o == instr_o[20:16]));

  a_r7_rtype_dest: assert property (@(posedge clk) disable iff (rst)
    (rf_we_o && op == OP_RTYPE) |-> rf_waddr_o == instr_o[15:11]);

  a_r9_unknown_quiet: assert property (@(posedge clk) disable iff (rst)
    (!known_op || (op == OP_RTYPE && fn != FN_ADD && fn != FN_SUB && fn != FN_AND &&
                   fn != FN_OR && fn != FN_SLT)) |-> !rf_we_o && !dm_we_o);

endmodule

bind onecyc_core core_chk u_chk (.*);

// File: tb/onecyc_core_test.sv
module onecyc_core_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pc_o, instr_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
  logic        rf_we_o, dm_we_o;
  logic [4:0]  rf_waddr_o;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  onecyc_core uut (
    .clk(clk), .rst(rst), .pc_o(pc_o), .instr_o(instr_o),
    .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
  );

  // behavioural reference state
  logic [31:0] m_reg  [32];
  logic [31:0] m_dmem [64];
  logic [31:0] m_imem [64];
  logic [31:0] m_pc;
  int          last_st = -1;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
  endfunction
  function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] enc_j(int word);
    return {6'd2, word[25:0]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (pc %h)", req, act, exp, m_pc);
    end
  endtask

  // compare the current instruction against the model, then advance the model
  task automatic step_and_compare();
    logic [31:0] ins, a, b, sx, res, npc, addr;
    logic [5:0]  op, fn;
    bit          wr, st;
    int          rd_n, widx;
    string       ptag;
    ins  = m_imem[m_pc[7:2]];
    op   = ins[31:26];
    fn   = ins[5:0];
    a    = (ins[25:21] == 0) ? 32'd0 : m_reg[ins[25:21]];
    b    = (ins[20:16] == 0) ? 32'd0 : m_reg[ins[20:16]];
    sx   = {{16{ins[15]}}, ins[15:0]};
    npc  = m_pc + 4;
    wr   = 1'b0; st = 1'b0; rd_n = 0; res = 0; addr = a + sx; ptag = "R2";
    case (op)
      6'd0: begin
        rd_n = ins[15:11]; wr = 1'b1;
        case (fn)
          6'h20: res = a + b;
          6'h22: res = a - b;
          6'h24: res = a & b;
          6'h25: res = a | b;
          6'h2A: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default: begin wr = 1'b0; ptag = "R9"; end
        endcase
      end
      6'd35: begin
        rd_n = ins[20:16]; wr = 1'b1; res = m_dmem[addr[7:2]];
      end
      6'd43: st = 1'b1;
      6'd4: begin
        ptag = "R3";
        if (a == b) npc = m_pc + 4 + (sx << 2);
      end
      6'd2: begin
        ptag = "R4";
        npc = {m_pc[31:28], ins[25:0], 2'b00};
      end
      default: ptag = "R9";
    endcase

    check(pc_o == m_pc, ptag, pc_o, m_pc);
    check(instr_o == ins, "R11", instr_o, ins);
    check(rf_we_o == wr, (ptag == "R9") ? "R9" : "R7", {31'd0, rf_we_o}, {31'd0, wr});
    check(dm_we_o == st, (ptag == "R9") ? "R9" : "R5", {31'd0, dm_we_o}, {31'd0, st});
    if (wr) begin
      check(rf_waddr_o == rd_n[4:0], (op == 6'd35) ? "R6" : "R7",
            {27'd0, rf_waddr_o}, rd_n);
      if (op == 6'd35 && int'(addr[7:2]) == last_st)
        check(rf_wdata_o == res, "R10", rf_wdata_o, res);
      else if (ins[25:21] == 0 || ins[20:16] == 0)
        check(rf_wdata_o == res, "R8", rf_wdata_o, res);
      else
        check(rf_wdata_o == res, (op == 6'd35) ? "R6" : "R7", rf_wdata_o, res);
    end
    if (st) begin
      check(dm_addr_o == addr, "R5", dm_addr_o, addr);
      check(dm_wdata_o == b, (ins[20:16] == 0) ? "R8" : "R5", dm_wdata_o, b);
    end

    if (wr && rd_n != 0) m_reg[rd_n] = res;
    if (st) begin
      widx = int'(addr[7:2]);
      m_dmem[widx] = b;
      last_st = widx;
    end
    m_pc = npc;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin m_imem[i] = 32'd0; m_dmem[i] = 32'd0; end
    for (int i = 0; i < 32; i++) m_reg[i] = 32'd0;
    m_dmem[0] = 32'd5;
    m_dmem[1] = 32'd7;
    m_dmem[2] = 32'd1;
    m_dmem[3] = 32'h40;
    m_dmem[9] = 32'hA5A5_0F0F;
    m_imem[0]  = enc_i(35, 0, 1, 0);
    m_imem[1]  = enc_i(35, 0, 2, 4);
    m_imem[2]  = enc_i(35, 0, 11, 8);
    m_imem[3]  = enc_i(35, 0, 9, 12);
    m_imem[4]  = enc_r(1, 2, 3, 'h20);
    m_imem[5]  = enc_r(1, 2, 4, 'h22);
    m_imem[6]  = enc_r(1, 2, 5, 'h24);
    m_imem[7]  = enc_r(1, 2, 6, 'h25);
    m_imem[8]  = enc_r(4, 1, 7, 'h2A);
    m_imem[9]  = enc_r(1, 4, 8, 'h2A);
    m_imem[10] = enc_r(1, 2, 0, 'h20);
    m_imem[11] = enc_i(43, 0, 0, 16);
    m_imem[12] = enc_i(43, 9, 3, -8);
    m_imem[13] = enc_i(35, 9, 13, -8);
    m_imem[14] = enc_r(13, 13, 14, 'h20);
    m_imem[15] = enc_i(8, 0, 1, 5);
    m_imem[16] = enc_i(4, 1, 2, 5);
    m_imem[17] = enc_i(4, 1, 1, 1);
    m_imem[18] = enc_r(1, 1, 15, 'h20);
    m_imem[19] = enc_r(10, 11, 10, 'h20);
    m_imem[20] = enc_r(10, 2, 12, 'h2A);
    m_imem[21] = enc_i(4, 12, 11, -3);
    m_imem[22] = enc_j(24);
    m_imem[23] = enc_r(1, 1, 16, 'h20);
    m_imem[24] = enc_i(43, 0, 14, 20);
    m_imem[25] = enc_i(43, 0, 10, 24);
    m_imem[26] = enc_r(1, 2, 17, 'h27);
    m_imem[27] = enc_i(35, 0, 18, 36);
    m_imem[28] = enc_r(0, 18, 19, 'h25);
    m_imem[29] = enc_j(29);
    for (int i = 0; i < 64; i++) begin
      uut.u_imem.cells[i] = m_imem[i];
      uut.u_dmem.cells[i] = m_dmem[i];
    end
    m_pc = 32'd0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pc_o == 32'd0, "R1", pc_o, 32'd0);
    rst = 1'b0;
    for (int c = 0; c < 90; c++) begin
      step_and_compare();
      @(negedge clk);
    end
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule